// File: doc/BRIEF.md
# Command packet sequencer

This block executes one command packet held in system memory. Given the address of a packet and a start pulse, it reads the 16-byte header through a 64-bit word memory port. It checks that the packet is marked valid and keeps the chaining pointer and the data-descriptor pointer. It then walks the list of register pairs that follows the header. Each pair whose address byte is not flagged "skip" becomes one write on the drive's task-file port. The walk stops at the pair whose address byte carries the end flag.

When the packet asks for a data phase and the list has written the command register, the block passes the descriptor pointer to a scatter-gather walker and waits until the walker reports completion. It finishes by writing a completion code into the response byte of the packet and pulsing `done_o`. It pulses `irq_o` as well when the packet requests an interrupt. If the packet is not valid, or its list runs out before an end-flagged pair, the block stops with `err_o` and leaves the packet untouched. A synchronous clear input returns the block to idle at any point.

Top module: `cmd_pkt_seq`

## Requirements
- R1: After reset the block is idle: `mem_req_o`, `tf_we_o`, `sg_start_o`, `done_o`, `err_o` and `irq_o` are all low.
- R2: On `start_i` the packet base is `pkt_addr_i` with its three low bits forced to zero. Header word 0 is read at the base and word 1 at base+8. Byte 2 of word 0 holds the flags (bit 0 valid, bit 2 has-data, bit 3 interrupt) and byte 3 holds the list length. Bytes 4..7 hold a little-endian next-packet pointer, which is presented on `next_ptr_o`. Bytes 0..3 of word 1 hold the little-endian descriptor pointer.
- R3: If the valid flag is clear, the block pulses `err_o` once and makes no task-file write and no memory write.
- R4: List word k is read at base+16+8k. Pair p of a word has its value in byte 2p and its address byte in byte 2p+1. Pairs are taken in ascending order, one per clock. Each pair writes `tf_data_o` = value and `tf_addr_o` = address byte bits 4:0.
- R5: A pair whose address byte has bit 5 set is consumed without a task-file write.
- R6: The pair whose address byte has bit 7 set is the last one; it is written unless its bit 5 is set. No later pair in that word or the packet is written.
- R7: The length byte gives the number of 64-bit list words. If it is zero, or no end-flagged pair occurs in those words, the block pulses `err_o` and writes no response.
- R8: When the has-data flag is set and a pair has written register 0x17, the block pulses `sg_start_o` for one clock with the descriptor on `sg_desc_o` after the end pair. It then holds the response write until `sg_done_i`. Otherwise `sg_start_o` stays low.
- R9: On success the block writes 0x01 to byte 0 of the packet word at the base, with byte strobe 0x01 only. It pulses `done_o` in the clock after that write is acknowledged.
- R10: `irq_o` pulses together with `done_o` exactly when the interrupt flag was set, and never on an error.
- R11: `clr_i` returns the block to idle at the next edge. No further memory request, task-file write, `done_o` or `err_o` follows from the aborted packet.
- R12: A memory request holds its address and direction until `mem_ack_i`; all addresses are 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous abort to idle |
| start_i | input | 1 | Start one packet |
| pkt_addr_i | input | 32 | Packet address, sampled with `start_i` |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address, 8-byte aligned |
| mem_wdata_o | output | 64 | Memory write data |
| mem_wstrb_o | output | 8 | Memory byte strobes |
| mem_rdata_i | input | 64 | Memory read data, valid with `mem_ack_i` |
| mem_ack_i | input | 1 | Memory acknowledge |
| tf_we_o | output | 1 | Task-file write strobe |
| tf_addr_o | output | 5 | Task-file register address |
| tf_data_o | output | 8 | Task-file write data |
| sg_start_o | output | 1 | Start pulse to the scatter-gather walker |
| sg_desc_o | output | 32 | First data descriptor address |
| sg_done_i | input | 1 | Scatter-gather walker finished |
| next_ptr_o | output | 32 | Next-packet pointer from the header |
| done_o | output | 1 | Packet completed pulse |
| err_o | output | 1 | Packet-state error pulse |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
With the bench memory answering one clock after a request, the first task-file write of a list word is due two clocks after that word's request is seen. The remaining pairs of the word follow on consecutive clocks. `done_o` is due exactly one clock after the acknowledged response write, and the bench checks this by stamping the cycle of that acknowledge. The task-file writes are compared in order against a queue of expected pairs built from the packet image. The outcome, interrupt, data-phase start and response byte are checked a fixed three clocks after `done_o` or `err_o`. The scatter-gather model checks at the start pulse that the response byte is still zero, and it answers six clocks later.

// File: rtl/cps_pkg.sv
package cps_pkg;

  localparam int TF_AW     = 5;
  localparam int HDR_BYTES = 16;

  // header flag bit positions inside byte 2
  localparam int FLG_VALID = 0;
  localparam int FLG_DATA  = 2;
  localparam int FLG_IRQ   = 3;

  // address byte bit positions
  localparam int PAIR_END  = 7;
  localparam int PAIR_SKIP = 5;

  localparam logic [TF_AW-1:0] REG_COMMAND = 5'h17;
  localparam logic [7:0]       RESP_DONE   = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR0,
    ST_HDR1,
    ST_LFETCH,
    ST_EMIT,
    ST_DATA,
    ST_RESP
  } cps_state_e;

  typedef struct packed {
    logic [7:0]       value;
    logic             last;
    logic             skip;
    logic [TF_AW-1:0] reg_addr;
  } cps_pair_t;

endpackage

// File: rtl/cps_pair_pick.sv
module cps_pair_pick
  import cps_pkg::*;
#(
  parameter  int DW     = 64,
  localparam int PAIRS  = DW / 16,
  localparam int PIDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic [DW-1:0]     word_i,
  input  logic [PIDX_W-1:0] idx_i,
  output cps_pair_t         pair_o
);

  cps_pair_t        slot [PAIRS];
  logic [PAIRS-1:0] rsvd_unused;

  for (genvar p = 0; p < PAIRS; p++) begin : g_slot
    assign slot[p].value    = word_i[16*p +: 8];
    assign slot[p].last     = word_i[16*p + 8 + PAIR_END];
    assign slot[p].skip     = word_i[16*p + 8 + PAIR_SKIP];
    assign slot[p].reg_addr = word_i[16*p + 8 +: TF_AW];
    assign rsvd_unused[p]   = word_i[16*p + 14];
  end

  assign pair_o = slot[idx_i];

endmodule

// File: rtl/cps_hdr_capture.sv
module cps_hdr_capture #(
  parameter int AW    = 32,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap0_i,
  input  logic             cap1_i,
  input  logic             data_flag_i,
  input  logic             irq_flag_i,
  input  logic [LEN_W-1:0] len_field_i,
  input  logic [AW-1:0]    next_field_i,
  input  logic [AW-1:0]    desc_field_i,
  output logic             has_data_o,
  output logic             irq_en_o,
  output logic [LEN_W-1:0] len_o,
  output logic [AW-1:0]    next_ptr_o,
  output logic [AW-1:0]    desc_ptr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_data_o <= 1'b0;
      irq_en_o   <= 1'b0;
      len_o      <= '0;
      next_ptr_o <= '0;
    end else if (cap0_i) begin
      has_data_o <= data_flag_i;
      irq_en_o   <= irq_flag_i;
      len_o      <= len_field_i;
      next_ptr_o <= next_field_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_ptr_o <= '0;
    end else if (cap1_i) begin
      desc_ptr_o <= desc_field_i;
    end
  end

endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
#(
  parameter  int AW      = 32,
  parameter  int DW      = 64,
  parameter  int LEN_W   = 8,
  localparam int PAIRS   = DW / 16,
  localparam int PIDX_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int WBYTES  = DW / 8,
  localparam int WORD_SH = $clog2(WBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [AW-1:0]     pkt_addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              cap0_o,
  output logic              cap1_o,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              has_data_i,
  input  logic              irq_en_i,
  output logic [DW-1:0]     pword_o,
  output logic [PIDX_W-1:0] pidx_o,
  input  cps_pair_t         pair_i,
  input  logic              sg_done_i,
  output logic              sg_start_o,
  output logic              tf_we_o,
  output logic [TF_AW-1:0]  tf_addr_o,
  output logic [7:0]        tf_data_o,
  output logic              done_o,
  output logic              err_o,
  output logic              irq_o
);

  cps_state_e        state_q, state_d;
  logic [AW-1:0]     base_q, base_d;
  logic [LEN_W-1:0]  widx_q, widx_d;
  logic [PIDX_W-1:0] pidx_q, pidx_d;
  logic [DW-1:0]     pword_q;
  logic              pword_en;
  logic              cmd_seen_q, cmd_seen_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              irq_q, irq_d;
  logic              sgs_q, sgs_d;
  logic              wr_now, cmd_now;
  logic [2:0]        addr_lsb_unused;

  assign addr_lsb_unused = pkt_addr_i[2:0];

  assign wr_now  = (state_q == ST_EMIT) && !pair_i.skip;
  assign cmd_now = wr_now && (pair_i.reg_addr == REG_COMMAND);

  // next-state process
  always_comb begin
    state_d    = state_q;
    base_d     = base_q;
    widx_d     = widx_q;
    pidx_d     = pidx_q;
    cmd_seen_d = cmd_seen_q;
    pword_en   = 1'b0;
    cap0_o     = 1'b0;
    cap1_o     = 1'b0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    irq_d      = 1'b0;
    sgs_d      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          base_d     = {pkt_addr_i[AW-1:3], 3'b000};
          cmd_seen_d = 1'b0;
          state_d    = ST_HDR0;
        end
      end
      ST_HDR0: begin
        if (mem_ack_i) begin
          cap0_o = 1'b1;
          if (!mem_rdata_i[16 + FLG_VALID]) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_HDR1;
          end
        end
      end
      ST_HDR1: begin
        if (mem_ack_i) begin
          cap1_o = 1'b1;
          if (len_i == '0) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            widx_d  = '0;
            state_d = ST_LFETCH;
          end
        end
      end
      ST_LFETCH: begin
        if (mem_ack_i) begin
          pword_en = 1'b1;
          pidx_d   = '0;
          state_d  = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (cmd_now) cmd_seen_d = 1'b1;
        if (pair_i.last) begin
          if (has_data_i && (cmd_seen_q || cmd_now)) begin
            sgs_d   = 1'b1;
            state_d = ST_DATA;
          end else begin
            state_d = ST_RESP;
          end
        end else if (pidx_q == PIDX_W'(PAIRS - 1)) begin
          if (widx_q == len_i - LEN_W'(1)) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            widx_d  = widx_q + 1'b1;
            state_d = ST_LFETCH;
          end
        end else begin
          pidx_d = pidx_q + 1'b1;
        end
      end
      ST_DATA: begin
        if (sg_done_i) state_d = ST_RESP;
      end
      ST_RESP: begin
        if (mem_ack_i) begin
          done_d  = 1'b1;
          irq_d   = irq_en_i;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (clr_i) begin
      state_d  = ST_IDLE;
      pword_en = 1'b0;
      cap0_o   = 1'b0;
      cap1_o   = 1'b0;
      done_d   = 1'b0;
      err_d    = 1'b0;
      irq_d    = 1'b0;
      sgs_d    = 1'b0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      widx_q     <= '0;
      pidx_q     <= '0;
      cmd_seen_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
      sgs_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      base_q     <= base_d;
      widx_q     <= widx_d;
      pidx_q     <= pidx_d;
      cmd_seen_q <= cmd_seen_d;
      done_q     <= done_d;
      err_q      <= err_d;
      irq_q      <= irq_d;
      sgs_q      <= sgs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pword_q <= '0;
    end else if (pword_en) begin
      pword_q <= mem_rdata_i;
    end
  end

  // memory port
  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = base_q;
    unique case (state_q)
      ST_HDR0:   mem_req_o = 1'b1;
      ST_HDR1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = base_q + AW'(WBYTES);
      end
      ST_LFETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = base_q + AW'(HDR_BYTES) + (AW'(widx_q) << WORD_SH);
      end
      ST_RESP: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign pword_o    = pword_q;
  assign pidx_o     = pidx_q;
  assign tf_we_o    = wr_now;
  assign tf_addr_o  = pair_i.reg_addr;
  assign tf_data_o  = pair_i.value;
  assign sg_start_o = sgs_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign irq_o      = irq_q;

endmodule

// File: rtl/cmd_pkt_seq.sv
module cmd_pkt_seq
  import cps_pkg::*;
#(
  parameter  int AW     = 32,
  parameter  int DW     = 64,
  parameter  int LEN_W  = 8,
  localparam int PAIRS  = DW / 16,
  localparam int PIDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int WBYTES = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [AW-1:0]     pkt_addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic [WBYTES-1:0] mem_wstrb_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              tf_we_o,
  output logic [TF_AW-1:0]  tf_addr_o,
  output logic [7:0]        tf_data_o,
  output logic              sg_start_o,
  output logic [AW-1:0]     sg_desc_o,
  input  logic              sg_done_i,
  output logic [AW-1:0]     next_ptr_o,
  output logic              done_o,
  output logic              err_o,
  output logic              irq_o
);

  logic              cap0, cap1;
  logic              has_data, irq_en;
  logic [LEN_W-1:0]  len;
  logic [DW-1:0]     pword;
  logic [PIDX_W-1:0] pidx;
  cps_pair_t         pair;

  cps_hdr_capture #(.AW(AW), .LEN_W(LEN_W)) u_hdr (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap0_i       (cap0),
    .cap1_i       (cap1),
    .data_flag_i  (mem_rdata_i[16 + FLG_DATA]),
    .irq_flag_i   (mem_rdata_i[16 + FLG_IRQ]),
    .len_field_i  (mem_rdata_i[24 +: LEN_W]),
    .next_field_i (mem_rdata_i[32 +: AW]),
    .desc_field_i (mem_rdata_i[0 +: AW]),
    .has_data_o   (has_data),
    .irq_en_o     (irq_en),
    .len_o        (len),
    .next_ptr_o   (next_ptr_o),
    .desc_ptr_o   (sg_desc_o)
  );

  cps_pair_pick #(.DW(DW)) u_pick (
    .word_i (pword),
    .idx_i  (pidx),
    .pair_o (pair)
  );

  cps_ctrl #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .start_i     (start_i),
    .pkt_addr_i  (pkt_addr_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .cap0_o      (cap0),
    .cap1_o      (cap1),
    .len_i       (len),
    .has_data_i  (has_data),
    .irq_en_i    (irq_en),
    .pword_o     (pword),
    .pidx_o      (pidx),
    .pair_i      (pair),
    .sg_done_i   (sg_done_i),
    .sg_start_o  (sg_start_o),
    .tf_we_o     (tf_we_o),
    .tf_addr_o   (tf_addr_o),
    .tf_data_o   (tf_data_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .irq_o       (irq_o)
  );

  assign mem_wdata_o = {{(DW-8){1'b0}}, RESP_DONE};
  assign mem_wstrb_o = WBYTES'(1);

endmodule

// File: rtl/cps_checks.sv
module cps_checks #(
  parameter int AW = 32,
  parameter int DW = 64,
  localparam int WBYTES = DW / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic [DW-1:0]     mem_wdata_o,
  input logic [WBYTES-1:0] mem_wstrb_o,
  input logic              mem_ack_i,
  input logic              tf_we_o,
  input logic              sg_start_o,
  input logic              done_o,
  input logic              err_o,
  input logic              irq_o
);

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i && !clr_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r12_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));

  a_r9_resp_content: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |->
      (mem_wdata_o[7:0] == 8'h01 && mem_wstrb_o == WBYTES'(1)));

  a_r9_done_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

  a_r10_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_o);

  a_r7_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  a_r8_sg_single: assert property (@(posedge clk) disable iff (!rst_n)
    sg_start_o |=> !sg_start_o);

  a_r4_no_write_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    tf_we_o |-> !mem_req_o);

  a_r11_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!mem_req_o && !tf_we_o && !done_o && !err_o && !sg_start_o));

endmodule

bind cmd_pkt_seq cps_checks #(.AW(AW), .DW(DW)) u_cps_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_wstrb_o (mem_wstrb_o),
  .mem_ack_i   (mem_ack_i),
  .tf_we_o     (tf_we_o),
  .sg_start_o  (sg_start_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .irq_o       (irq_o)
);

// File: tb/test_cmd_pkt_seq.sv
module test_cmd_pkt_seq;

  logic        clk, rst_n, clr_i, start_i;
  logic [31:0] pkt_addr_i;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_wdata_o, mem_rdata_i;
  logic [7:0]  mem_wstrb_o;
  logic        tf_we_o;
  logic [4:0]  tf_addr_o;
  logic [7:0]  tf_data_o;
  logic        sg_start_o, sg_done_i;
  logic [31:0] sg_desc_o, next_ptr_o;
  logic        done_o, err_o, irq_o;

  cmd_pkt_seq i_cmd_pkt_seq (.*);

  typedef struct { logic [4:0] a; logic [7:0] d; } wr_t;

  logic [63:0] mem [0:63];
  wr_t         expq[$];
  logic [7:0]  pv[$];
  logic [7:0]  pa[$];
  int cyc, vectors, miscompares;
  int done_cnt, err_cnt, irq_cnt, sg_cnt, wr_cnt, wb_cyc, cur_bw;
  logic [31:0] exp_desc;

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // memory model: answers one clock after a request
  initial begin
    cyc = 0;
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(posedge clk);
      cyc++;
      if (mem_req_o && !mem_ack_i) begin
        mem_ack_i <= 1'b1;
        if (mem_we_o) begin
          for (int b = 0; b < 8; b++)
            if (mem_wstrb_o[b]) mem[mem_addr_o[8:3]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
        end else begin
          mem_rdata_i <= mem[mem_addr_o[8:3]];
        end
      end else begin
        mem_ack_i <= 1'b0;
      end
    end
  end

  // scatter-gather walker model
  initial begin
    sg_done_i = 1'b0;
    forever begin
      @(negedge clk);
      if (sg_start_o) begin
        repeat (6) @(negedge clk);
        sg_done_i = 1'b1;
        @(negedge clk);
        sg_done_i = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    done_cnt = 0; err_cnt = 0; irq_cnt = 0; sg_cnt = 0; wr_cnt = 0; wb_cyc = -10;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (tf_we_o) begin
          wr_cnt++;
          if (expq.size() == 0) begin
            vectors++;
            miscompares++;
            $display("FAIL R6 unexpected write act=%0h/%0h exp=none", tf_addr_o, tf_data_o);
          end else begin
            wr_t e;
            e = expq.pop_front();
            chk("R4 task-file write", {tf_addr_o, tf_data_o}, {e.a, e.d});
          end
        end
        if (mem_req_o && mem_we_o && mem_ack_i) wb_cyc = cyc;
        if (done_o) begin
          done_cnt++;
          chk("R9 done one clock after response ack", 64'(cyc - wb_cyc), 64'd1);
        end
        if (err_o) err_cnt++;
        if (irq_o) irq_cnt++;
        if (sg_start_o) begin
          sg_cnt++;
          chk("R8 descriptor", sg_desc_o, exp_desc);
          chk("R8 response held before data phase", mem[cur_bw][7:0], 8'h00);
        end
      end
    end
  end

  task automatic clear_pairs();
    pv.delete();
    pa.delete();
  endtask

  task automatic pair(input logic [7:0] v, input logic [7:0] a);
    pv.push_back(v);
    pa.push_back(a);
  endtask

  // builds the packet image and the expected writes; returns expected outcome
  task automatic load_pkt(input int bw, input logic [7:0] flags, input logic [7:0] len,
                          input logic [31:0] nxt, input logic [31:0] desc,
                          output bit ok, output bit cmd, output logic [63:0] w0);
    logic [7:0] sv[$];
    logic [7:0] sa[$];
    bit found;
    sv = pv;
    sa = pa;
    while (sv.size() < 4 * int'(len)) begin
      sv.push_back(8'h5A);
      sa.push_back(8'h13);
    end
    expq.delete();
    found = 1'b0;
    cmd = 1'b0;
    if (flags[0] && len != 0) begin
      for (int i = 0; i < 4 * int'(len) && !found; i++) begin
        if (!sa[i][5]) begin
          expq.push_back('{sa[i][4:0], sv[i]});
          if (sa[i][4:0] == 5'h17) cmd = 1'b1;
        end
        if (sa[i][7]) found = 1'b1;
      end
    end
    ok = flags[0] && (len != 0) && found;
    exp_desc = desc;
    cur_bw = bw;
    w0 = {nxt, len, flags, 8'hC3, 8'h00};
    mem[bw] = w0;
    mem[bw + 1] = {32'hC0FFEE11, desc};
    for (int k = 0; k < int'(len); k++) begin
      logic [63:0] w;
      w = '0;
      for (int p = 0; p < 4; p++) begin
        w[16*p +: 8]     = sv[4*k + p];
        w[16*p + 8 +: 8] = sa[4*k + p];
      end
      mem[bw + 2 + k] = w;
    end
  endtask

  task automatic kick(input int bw, input logic [2:0] low);
    @(negedge clk);
    pkt_addr_i = 32'(bw * 8) | {29'd0, low};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_pkt(input string tag, input int bw, input logic [2:0] low,
                         input logic [7:0] flags, input logic [7:0] len,
                         input logic [31:0] nxt, input logic [31:0] desc);
    bit ok, cmd;
    logic [63:0] w0;
    int d0, e0, i0, s0;
    load_pkt(bw, flags, len, nxt, desc, ok, cmd, w0);
    d0 = done_cnt; e0 = err_cnt; i0 = irq_cnt; s0 = sg_cnt;
    kick(bw, low);
    for (int t = 0; t < 3000 && done_cnt == d0 && err_cnt == e0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk({tag, " done count"}, 64'(done_cnt - d0), ok ? 64'd1 : 64'd0);
    chk({tag, " error count"}, 64'(err_cnt - e0), ok ? 64'd0 : 64'd1);
    chk("R4 all expected writes seen", 64'(expq.size()), 64'd0);
    chk("R10 interrupt count", 64'(irq_cnt - i0), (ok && flags[3]) ? 64'd1 : 64'd0);
    chk("R8 data phase starts", 64'(sg_cnt - s0), (ok && flags[2] && cmd) ? 64'd1 : 64'd0);
    chk("R9 response byte", mem[bw][7:0], ok ? 8'h01 : 8'h00);
    chk("R9 rest of header word", mem[bw][63:8], w0[63:8]);
    if (flags[0]) chk("R2 next pointer", next_ptr_o, nxt);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit ok, cmd;
    logic [63:0] w0;
    int d0, e0, n0;
    vectors = 0;
    miscompares = 0;
    rst_n = 1'b0;
    clr_i = 1'b0;
    start_i = 1'b0;
    pkt_addr_i = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mem_req idle", mem_req_o, 0);
    chk("R1 tf_we idle", tf_we_o, 0);
    chk("R1 done idle", done_o, 0);
    chk("R1 err idle", err_o, 0);
    chk("R1 sg_start idle", sg_start_o, 0);
    chk("R1 irq idle", irq_o, 0);

    // R4 R5 R6 R10: 48-bit style list with a skipped pair, interrupt set
    clear_pairs();
    pair(8'hE0, 8'h16); pair(8'h00, 8'h12); pair(8'h01, 8'h13); pair(8'h02, 8'h14);
    pair(8'h03, 8'h15); pair(8'h08, 8'h12); pair(8'h11, 8'h13); pair(8'h22, 8'h14);
    pair(8'h33, 8'h15); pair(8'h00, 8'h0E); pair(8'h99, 8'h20); pair(8'hC8, 8'h97);
    run_pkt("R6 basic", 0, 3'b000, 8'h09, 8'd3, 32'h0000_1230, 32'h0000_4000);

    // R8 R2: data phase after command write, unaligned pointer
    clear_pairs();
    pair(8'h40, 8'h16); pair(8'h25, 8'h97);
    run_pkt("R8 data", 8, 3'b101, 8'h05, 8'd1, 32'h8765_4320, 32'hABCD_0008);

    // R3: valid flag clear
    clear_pairs();
    pair(8'h40, 8'h16); pair(8'h25, 8'h97);
    run_pkt("R3 invalid", 16, 3'b000, 8'h0C, 8'd1, 32'h0, 32'h1000);

    // R7: no end marker within the length
    clear_pairs();
    pair(8'h01, 8'h12); pair(8'h02, 8'h13); pair(8'h03, 8'h14); pair(8'h04, 8'h15);
    pair(8'hC8, 8'h97);
    run_pkt("R7 no end", 24, 3'b000, 8'h09, 8'd1, 32'h0, 32'h2000);

    // R7: zero length
    clear_pairs();
    pair(8'hC8, 8'h97);
    run_pkt("R7 zero length", 32, 3'b000, 8'h01, 8'd0, 32'h0000_0040, 32'h3000);

    // R6 R5 R8: end pair that is also skipped, has-data without command
    clear_pairs();
    pair(8'h10, 8'h12); pair(8'h77, 8'hB3); pair(8'hC8, 8'h17); pair(8'hC8, 8'h17);
    run_pkt("R6 skipped end", 40, 3'b010, 8'h0D, 8'd2, 32'h0000_0080, 32'h5000);

    // R11: clear in the middle of the list
    clear_pairs();
    for (int i = 0; i < 7; i++) pair(8'(i + 1), 8'h12);
    pair(8'hC8, 8'h97);
    load_pkt(48, 8'h0D, 8'd2, 32'h0, 32'h6000, ok, cmd, w0);
    d0 = done_cnt; e0 = err_cnt; n0 = wr_cnt;
    kick(48, 3'b000);
    for (int t = 0; t < 200 && wr_cnt < n0 + 2; t++) @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    expq.delete();
    chk("R11 no request after clear", mem_req_o, 0);
    n0 = wr_cnt;
    repeat (40) @(negedge clk);
    chk("R11 no writes after clear", 64'(wr_cnt - n0), 64'd0);
    chk("R11 no done", 64'(done_cnt - d0), 64'd0);
    chk("R11 no error", 64'(err_cnt - e0), 64'd0);
    chk("R11 response untouched", mem[48][7:0], 8'h00);

    // recovery after clear
    clear_pairs();
    pair(8'hA0, 8'h16); pair(8'h00, 8'h2E); pair(8'h35, 8'h97);
    run_pkt("R9 after clear", 56, 3'b000, 8'h05, 8'd1, 32'h0000_00C0, 32'h7000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule